// File: doc/BRIEF.md
# Dual-Channel Capture Timer with Overflow Lock

This block is a 16-bit up-counting timer with two capture channels. When a channel sees a capture strobe, it stores the timer value of that cycle in its 16-bit register, which software reads one byte at a time. If a second strobe arrives before both bytes of the stored value have been read, the channel raises its overflow flag. It then keeps the first value and ignores further strobes until both bytes have been read.

Channel 0's register has two roles, chosen by a mode input. In capture mode it is an ordinary capture register and the timer runs freely through its full 16-bit range. In period mode the register holds the timer's terminal count and is loaded through two byte write strobes. In that mode channel 0 ignores its capture and read strobes.

Top module: `capTimer`

## Requirements
- R1: After reset, `tmrVal`, both entries of `capVal` and both bits of `capOvf` are 0.
- R2: The timer holds its value while `runEn` is 0. While `runEn` is 1 it advances by one per clock.
- R3: With `capMode` at 1, the timer is not limited by channel 0's register. It counts past that value and wraps from 0xFFFF to 0.
- R4: With `capMode` at 0 and `runEn` at 1, on the clock after `tmrVal` equals `capVal[0]` the timer becomes 0. A period of 0 holds the timer at 0.
- R5: With `capMode` at 0, `wrLo` loads `wrByte` into bits 7:0 of channel 0's register and `wrHi` loads it into bits 15:8. With `capMode` at 1, both write strobes are ignored.
- R6: With `capMode` at 0, channel 0's capture and read strobes have no effect: `capVal[0]` keeps the period and `capOvf[0]` stays 0.
- R7: A capture strobe on a channel with no unread value stores the timer value of the strobe's cycle. That value appears on `capVal` one clock later.
- R8: A capture strobe on a channel that holds an unread value sets that channel's `capOvf` bit on the next clock and leaves its register unchanged. The other channel is unaffected.
- R9: While a channel's overflow flag is 1, further capture strobes do not change its register.
- R10: A stored value counts as read only once both `rdLo` and `rdHi` have been strobed for the channel, in either order or in the same cycle. Completing the read clears the overflow flag on the next clock, and the next strobe captures again.
- R11: A capture strobe in the same cycle that completes a read stores the new timer value. The new value counts as unread and the overflow flag is 0.
- R12: Read strobes given while a channel holds no unread value are not remembered. They do not count toward reading a later capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Timer count enable |
| capMode | input | 1 | 1: channel 0 captures; 0: channel 0 holds the period |
| capEvt | input | 2 | Single-cycle capture strobes, one per channel |
| rdLo | input | 2 | Low-byte read strobes, one per channel |
| rdHi | input | 2 | High-byte read strobes, one per channel |
| wrLo | input | 1 | Period low-byte write strobe |
| wrHi | input | 1 | Period high-byte write strobe |
| wrByte | input | 8 | Period write data |
| tmrVal | output | 16 | Current timer value |
| capVal | output | 2x16 | Register contents of each channel |
| capOvf | output | 2 | Overflow flag of each channel |

## Verification
Captures are run on both channels across three read orders (low first, high first, both together) and several idle gaps before the read. A follow-up strobe then shows whether the read was actually recognised: it either captures or raises overflow. Overflow sequences, including a half-finished read, show the difference between a locked channel and a free one. A strobe that coincides with read completion shows that the new value is taken. Stray read strobes given before a capture show that they are not remembered. Periods 0 through 6, plus one period with a nonzero high byte, are swept over several full wraps and compared with the arithmetic count modulo period+1. Each sweep also applies channel 0 strobes to confirm that they have no effect in that mode.

// File: rtl/capTimerPkg.sv
`timescale 1ns/1ps
package capTimerPkg;
  localparam int NUM_CH    = 2;
  localparam int SHARED_CH = 0;

  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic              wrLo;
    logic              wrHi;
  } dpStrobe_t;
endpackage

// File: rtl/capCtrl.sv
`timescale 1ns/1ps
module capCtrl
  import capTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              capMode,
  input  logic [NUM_CH-1:0] capEvt,
  input  logic [NUM_CH-1:0] rdLo,
  input  logic [NUM_CH-1:0] rdHi,
  input  logic              wrLo,
  input  logic              wrHi,
  output dpStrobe_t         strobe,
  output logic [NUM_CH-1:0] capOvf
);
  logic [NUM_CH-1:0] loadVec;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic unread, ovf, seenLo, seenHi;
    logic active, evt, gotLo, gotHi, done, load;

    if (ch == SHARED_CH) begin : g_shared
      assign active = capMode;
    end else begin : g_plain
      assign active = 1'b1;
    end

    assign evt   = capEvt[ch] & active;
    assign gotLo = seenLo | (rdLo[ch] & active);
    assign gotHi = seenHi | (rdHi[ch] & active);
    assign done  = unread & gotLo & gotHi;
    // a strobe loads when nothing is pending or the pending value is read now
    assign load  = evt & (~unread | done);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        unread <= 1'b0;
        ovf    <= 1'b0;
        seenLo <= 1'b0;
        seenHi <= 1'b0;
      end else if (load) begin
        unread <= 1'b1;
        ovf    <= 1'b0;
        seenLo <= 1'b0;
        seenHi <= 1'b0;
      end else if (done) begin
        unread <= 1'b0;
        ovf    <= 1'b0;
        seenLo <= 1'b0;
        seenHi <= 1'b0;
      end else if (unread) begin
        ovf    <= ovf | evt;
        seenLo <= gotLo;
        seenHi <= gotHi;
      end
    end

    assign loadVec[ch] = load;
    assign capOvf[ch]  = ovf;
  end

  assign strobe = '{load: loadVec, wrLo: wrLo & ~capMode, wrHi: wrHi & ~capMode};
endmodule

// File: rtl/capDatapath.sv
`timescale 1ns/1ps
module capDatapath
  import capTimerPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             runEn,
  input  logic                             capMode,
  input  dpStrobe_t                        strobe,
  input  logic [BYTE_W-1:0]                wrByte,
  output logic [2*BYTE_W-1:0]              tmrVal,
  output logic [NUM_CH-1:0][2*BYTE_W-1:0]  capVal
);
  localparam int TMR_W = 2 * BYTE_W;

  logic [TMR_W-1:0] tmr;
  logic             atPeriod;

  assign atPeriod = ~capMode & (tmr == capVal[SHARED_CH]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      tmr <= '0;
    else if (runEn) tmr <= atPeriod ? '0 : tmr + TMR_W'(1);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_reg
    logic [TMR_W-1:0] hold;

    if (ch == SHARED_CH) begin : g_shared
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hold <= '0;
        else if (strobe.load[ch]) hold <= tmr;
        else begin
          if (strobe.wrLo) hold[BYTE_W-1:0]     <= wrByte;
          if (strobe.wrHi) hold[TMR_W-1:BYTE_W] <= wrByte;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                hold <= '0;
        else if (strobe.load[ch]) hold <= tmr;
      end
    end

    assign capVal[ch] = hold;
  end

  assign tmrVal = tmr;
endmodule

// File: rtl/capTimer.sv
`timescale 1ns/1ps
module capTimer
  import capTimerPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            runEn,
  input  logic                            capMode,
  input  logic [1:0]                      capEvt,
  input  logic [1:0]                      rdLo,
  input  logic [1:0]                      rdHi,
  input  logic                            wrLo,
  input  logic                            wrHi,
  input  logic [BYTE_W-1:0]               wrByte,
  output logic [2*BYTE_W-1:0]             tmrVal,
  output logic [1:0][2*BYTE_W-1:0]        capVal,
  output logic [1:0]                      capOvf
);
  dpStrobe_t strobe;

  capCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .capMode (capMode),
    .capEvt  (capEvt),
    .rdLo    (rdLo),
    .rdHi    (rdHi),
    .wrLo    (wrLo),
    .wrHi    (wrHi),
    .strobe  (strobe),
    .capOvf  (capOvf)
  );

  capDatapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .capMode (capMode),
    .strobe  (strobe),
    .wrByte  (wrByte),
    .tmrVal  (tmrVal),
    .capVal  (capVal)
  );
endmodule

// File: rtl/capTimerChk.sv
`timescale 1ns/1ps
module capTimerChk #(
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     runEn,
  input logic                     capMode,
  input logic [1:0]               capEvt,
  input logic [1:0]               rdLo,
  input logic [1:0]               rdHi,
  input logic                     wrLo,
  input logic [BYTE_W-1:0]        wrByte,
  input logic [2*BYTE_W-1:0]      tmrVal,
  input logic [1:0][2*BYTE_W-1:0] capVal,
  input logic [1:0]               capOvf
);
  localparam int TMR_W = 2 * BYTE_W;

  // R2
  hold_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(tmrVal));

  // R3
  free_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && capMode) |=> tmrVal == ($past(tmrVal) + TMR_W'(1)));

  // R4
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !capMode && tmrVal == capVal[0]) |=> tmrVal == '0);

  // R5
  period_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!capMode && wrLo) |=> capVal[0][BYTE_W-1:0] == $past(wrByte));

  // R6
  period_noovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!capMode && !capOvf[0]) |=> !capOvf[0]);

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capOvf[1]) |-> $past(capEvt[1]));

  // R9
  ovf_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capOvf[1] && !rdLo[1] && !rdHi[1]) |=> $stable(capVal[1]));

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capOvf[1]) |-> $past(rdLo[1] || rdHi[1]));
endmodule

bind capTimer capTimerChk #(.BYTE_W(BYTE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .capMode (capMode),
  .capEvt  (capEvt),
  .rdLo    (rdLo),
  .rdHi    (rdHi),
  .wrLo    (wrLo),
  .wrByte  (wrByte),
  .tmrVal  (tmrVal),
  .capVal  (capVal),
  .capOvf  (capOvf)
);

// File: tb/test_capTimer.sv
`timescale 1ns/1ps
module test_capTimer;
  localparam int BW = 8;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN, runEn, capMode, wrLo, wrHi;
  logic [1:0]        capEvt, rdLo, rdHi;
  logic [BW-1:0]     wrByte;
  logic [TW-1:0]     tmrVal;
  logic [1:0][TW-1:0] capVal;
  logic [1:0]        capOvf;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [TW-1:0] mt;
  logic [TW-1:0] expPer;

  capTimer #(.BYTE_W(BW)) i_capTimer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .capMode(capMode),
    .capEvt(capEvt), .rdLo(rdLo), .rdHi(rdHi), .wrLo(wrLo), .wrHi(wrHi),
    .wrByte(wrByte), .tmrVal(tmrVal), .capVal(capVal), .capOvf(capOvf)
  );

  // arithmetic timer model from R2, R3, R4
  always @(posedge clk) begin
    if (!rstN)      mt <= '0;
    else if (runEn) mt <= (!capMode && mt == expPer) ? '0 : mt + TW'(1);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] e, input logic [1:0] lo, input logic [1:0] hi);
    capEvt = e; rdLo = lo; rdHi = hi;
    tick();
    capEvt = '0; rdLo = '0; rdHi = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0; runEn = 1'b0; capMode = 1'b1;
    capEvt = '0; rdLo = '0; rdHi = '0; wrLo = 1'b0; wrHi = 1'b0; wrByte = '0;
    expPer = '0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic writePer(input logic [TW-1:0] p);
    wrByte = p[BW-1:0]; wrLo = 1'b1; tick(); wrLo = 1'b0;
    wrByte = p[TW-1:BW]; wrHi = 1'b1; tick(); wrHi = 1'b0;
    expPer = p;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] e1, e2, v;
    rstN = 1'b0;
    @(negedge clk);
    doReset();

    // R1 reset state
    chk("R1 tmrVal", tmrVal, 0);
    chk("R1 capVal0", capVal[0], 0);
    chk("R1 capVal1", capVal[1], 0);
    chk("R1 capOvf", capOvf, 0);

    // R2 hold while disabled, then count
    repeat (4) tick();
    chk("R2 hold", tmrVal, 0);
    runEn = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      chk("R2 count", tmrVal, k);
    end
    runEn = 1'b0;
    tick(); tick();
    chk("R2 stop", tmrVal, 10);
    runEn = 1'b1;

    // R7 / R10: capture, every read order, several gaps
    for (int ch = 0; ch < 2; ch++) begin
      for (int order = 0; order < 3; order++) begin
        for (int gap = 0; gap < 4; gap++) begin
          logic [1:0] m;
          m = 2'(1 << ch);
          e1 = mt;
          pulse(m, 2'b00, 2'b00);
          chk("R7 capture", capVal[ch], e1);
          chk("R7 no ovf", capOvf, 0);
          repeat (gap) tick();
          if (order == 0) begin
            pulse(2'b00, m, 2'b00); chk("R10 half read", capOvf, 0);
            pulse(2'b00, 2'b00, m);
          end else if (order == 1) begin
            pulse(2'b00, 2'b00, m);
            pulse(2'b00, m, 2'b00);
          end else begin
            pulse(2'b00, m, m);
          end
          e2 = mt;
          pulse(m, 2'b00, 2'b00);
          chk("R10 recapture", capVal[ch], e2);
          chk("R10 no ovf", capOvf, 0);
          pulse(2'b00, m, m);
        end
      end
    end

    // R8 / R9 / R10 overflow lock on each channel
    for (int ch = 0; ch < 2; ch++) begin
      logic [1:0] m;
      m = 2'(1 << ch);
      e1 = mt;
      pulse(m, 2'b00, 2'b00);
      tick();
      pulse(m, 2'b00, 2'b00);
      chk("R8 ovf set", capOvf[ch], 1);
      chk("R8 other ch", capOvf[1-ch], 0);
      chk("R8 value kept", capVal[ch], e1);
      pulse(m, 2'b00, 2'b00);
      chk("R9 locked", capVal[ch], e1);
      pulse(2'b00, m, 2'b00);
      chk("R10 half read ovf", capOvf[ch], 1);
      pulse(m, 2'b00, 2'b00);
      chk("R9 locked after half", capVal[ch], e1);
      pulse(2'b00, 2'b00, m);
      chk("R10 ovf cleared", capOvf[ch], 0);
      e2 = mt;
      pulse(m, 2'b00, 2'b00);
      chk("R10 resumes", capVal[ch], e2);

      // R11 strobe coinciding with read completion
      pulse(2'b00, m, 2'b00);
      e2 = mt;
      pulse(m, 2'b00, m);
      chk("R11 new value", capVal[ch], e2);
      chk("R11 ovf low", capOvf[ch], 0);
      pulse(m, 2'b00, 2'b00);
      chk("R11 counts unread", capOvf[ch], 1);
      pulse(2'b00, m, m);
      chk("R11 cleared", capOvf[ch], 0);

      // R12 stray read before capture
      pulse(2'b00, 2'b00, m);
      pulse(m, 2'b00, 2'b00);
      pulse(2'b00, m, 2'b00);
      pulse(m, 2'b00, 2'b00);
      chk("R12 stray read", capOvf[ch], 1);
      pulse(2'b00, m, m);
    end

    // R3 timer passes channel 0 value in capture mode
    runEn = 1'b0;
    e1 = mt;
    pulse(2'b01, 2'b00, 2'b00);
    pulse(2'b00, 2'b01, 2'b01);
    chk("R3 cap equals", capVal[0], e1);
    runEn = 1'b1;
    tick();
    chk("R3 no limit", tmrVal, e1 + TW'(1));

    // R5 writes ignored in capture mode
    v = capVal[0];
    wrByte = 8'hA5; wrLo = 1'b1; tick(); wrLo = 1'b0;
    wrHi = 1'b1; tick(); wrHi = 1'b0;
    chk("R5 write ignored", capVal[0], v);

    // R4 / R5 / R6 period sweep
    for (int p = 0; p <= 6; p++) begin
      doReset();
      capMode = 1'b0;
      writePer(TW'(p));
      chk("R5 period write", capVal[0], p);
      runEn = 1'b1;
      for (int k = 1; k <= 3 * (p + 1); k++) begin
        tick();
        chk("R4 wrap", tmrVal, k % (p + 1));
      end
      pulse(2'b01, 2'b00, 2'b00);
      pulse(2'b01, 2'b01, 2'b01);
      pulse(2'b01, 2'b00, 2'b00);
      chk("R6 period kept", capVal[0], p);
      chk("R6 no ovf", capOvf[0], 0);
    end

    // R4 / R5 period with a nonzero high byte
    doReset();
    capMode = 1'b0;
    writePer(16'h0103);
    chk("R5 high byte", capVal[0], 16'h0103);
    runEn = 1'b1;
    repeat (16'h0103) tick();
    chk("R4 at period", tmrVal, 16'h0103);
    tick();
    chk("R4 wrapped", tmrVal, 0);
    tick();
    chk("R4 after wrap", tmrVal, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule